// File: doc/BRIEF.md
# Programmable Timer and Event Counter

This block is an 8-bit up-counter peripheral driven by a small register bus. It has three ways to advance. It can count qualifying edges on an external input. It can count ticks of an internal reference after a programmable power-of-two prescaler. It can also measure how long the external input stays at its active level, counted in prescaled ticks.

The bus has two addresses. The data address holds two registers behind it: a write goes to a reload register, and a read returns the live count. The control address holds the prescaler code, the edge polarity, the run enable and the mode.

When the count passes 0xFF, the counter reloads from the reload register. At the same moment it sets a sticky overflow flag and toggles a divider output. With reload value N, this divider output runs at the prescaled rate divided by 2×(256−N).

The internal reference arrives as a one-cycle enable input, `tick_en`. The external input is asynchronous and passes through a two-flop synchronizer before edges are detected.

Top module: `evt_timer`

## Requirements
- R1: After synchronous active-low reset, the control register, counter, reload register, overflow flag and divider output are all 0.
- R2: With `addr`=0, a write stores only the reload register and leaves the count unchanged. A read at `addr`=0 returns the live count.
- R3: With `addr`=1, a write stores the control byte and a read returns it, except bit 5, which always reads 0. The field layout is: bits 2:0 prescaler code, bit 3 edge polarity, bit 4 run enable, bits 7:6 mode.
- R4: In timer mode (bits 7:6 = 10), the count advances once per 2^(code+1) cycles with `tick_en` high. Every write to the control register restarts the prescaler from zero.
- R5: In event mode (bits 7:6 = 01), each synchronized edge of `ext_in` of the selected polarity advances the count by exactly one. Bit 3 = 0 selects low-to-high and bit 3 = 1 selects high-to-low. Edges of the other polarity are ignored.
- R6: While bit 4 is 0, the count holds in every mode.
- R7: With bits 7:6 = 00, the count holds even when bit 4 is 1.
- R8: A count step taken from 0xFF loads the reload value instead of 0, sets the overflow flag and toggles `pfd_out`.
- R9: With reload value N, `pfd_out` toggles once every 256−N count steps.
- R10: In pulse-width mode (bits 7:6 = 11), the count advances on prescaled ticks only while the synchronized input is at its active level: high when bit 3 = 0, low when bit 3 = 1. The return to the inactive level clears bit 4, which freezes the result.
- R11: The overflow flag stays set until the next control write clears it. If an overflow occurs in the same cycle as that write, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 1 | Register select: 0 data, 1 control |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| tick_en | input | 1 | One-cycle pulse of the internal reference |
| ext_in | input | 1 | Asynchronous external input |
| ovf_flag | output | 1 | Sticky overflow flag |
| pfd_out | output | 1 | Divider output, toggles on each overflow |

## Verification
Several corner cases are exercised:

- **Overflow:** the bench runs the count past 0xFF with a reload value near the top. A design that wrapped to zero, or never toggled the divider, reports the wrong count or divider level. A divider period other than 2×(256−N) shows up in the same test.
- **Prescaler restart:** the bench leaves a partly advanced prescaler, rewrites the control register, and checks that one more tick adds nothing.
- **Edge polarity:** event-mode checks drive both polarities and expect the unselected edges to be ignored. A design that counted both edges would double the count.
- **Pulse-width end:** the bench checks that the end of the pulse clears the enable bit. It then checks that a later pulse does not change the held result.
- **Disabled and unused modes:** the bench drives edges and ticks with the enable off and with mode 00, and expects the count to stay still.

// File: rtl/evt_timer_pkg.sv
// Shared definitions for the timer/event counter: widths, control field
// positions and the mode encoding. Assumes an 8-bit bus.
package evt_timer_pkg;
    localparam int CNT_W   = 8;
    localparam int PSC_W   = 3;
    localparam int PSC_LEN = 1 << PSC_W;   // prescaler counter width

    localparam int CB_EDGE = 3;
    localparam int CB_RUN  = 4;
    localparam int CB_RSVD = 5;
    localparam int CB_MODE = 6;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmode_e;
endpackage

// File: rtl/evt_timer_sync.sv
// Two-flop synchronizer for the external input, followed by a history flop
// that gives rise/fall detection. Assumes ext_in may change at any time.
module evt_timer_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    // Purpose: move the input into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Purpose: derive level and single-cycle edge strobes.
    always_comb begin
        level = s2_q;
        rise  = s2_q & ~s3_q;
        fall  = ~s2_q & s3_q;
    end
endmodule

// File: rtl/evt_timer_psc.sv
// Power-of-two prescaler on the internal reference enable. The division is
// 2^(code+1). A clear restarts the phase. Assumes tick_en is a one-cycle strobe.
module evt_timer_psc #(
    parameter int CODE_W = 3,
    localparam int LEN   = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] code,
    output logic              psc_tick
);
    logic [LEN-1:0] pcnt_q;
    logic [LEN-1:0] mask;

    // Purpose: advance the prescaler on each reference tick, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt_q <= '0;
        else if (tick_en)  pcnt_q <= pcnt_q + 1'b1;
    end

    // Purpose: emit a strobe when the low code+1 bits are all ones.
    always_comb begin
        mask     = {LEN{1'b1}} >> (LEN - 1 - int'(code));
        psc_tick = tick_en && ((pcnt_q & mask) == mask);
    end
endmodule

// File: rtl/evt_timer_core.sv
// Count register with auto-reload, sticky overflow flag and divider toggle.
// Assumes step is a one-cycle strobe. The flag set has priority over its clear.
module evt_timer_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] reload,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         ovf_flag,
    output logic         pfd_out
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic wrap;

    // Purpose: detect a step taken from the top value.
    always_comb wrap = step && (cnt == TOP);

    // Purpose: count up, reloading instead of wrapping to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= reload;
        else if (step) cnt <= cnt + 1'b1;
    end

    // Purpose: keep the sticky flag and toggle the divider on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            pfd_out  <= 1'b0;
        end else begin
            if (wrap)          ovf_flag <= 1'b1;
            else if (flag_clr) ovf_flag <= 1'b0;
            if (wrap)          pfd_out  <= ~pfd_out;
        end
    end
endmodule

// File: rtl/evt_timer.sv
// Top of the timer/event counter. It holds the register decode, the control and
// reload registers, and the mode selection of the count strobe.
// Assumes a single-cycle write strobe and a combinational read path.
module evt_timer
    import evt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tick_en,
    input  logic             ext_in,
    output logic             ovf_flag,
    output logic             pfd_out
);
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ctrl_wr, data_wr;
    logic             lvl, rise, fall, psc_tick;
    logic             run_en, edge_neg, active_lvl, hit_edge, end_edge;
    logic             count_evt, pw_done;
    tmode_e           mode;

    // Purpose: decode the bus writes and the control fields.
    always_comb begin
        ctrl_wr    = wr_en && addr;
        data_wr    = wr_en && !addr;
        run_en     = ctrl_q[CB_RUN];
        edge_neg   = ctrl_q[CB_EDGE];
        mode       = tmode_e'(ctrl_q[CB_MODE +: 2]);
        active_lvl = edge_neg ? ~lvl : lvl;
        hit_edge   = edge_neg ? fall : rise;
        end_edge   = edge_neg ? rise : fall;
    end

    // Purpose: choose the count strobe and the end of a pulse measurement.
    always_comb begin
        count_evt = 1'b0;
        unique case (mode)
            MODE_EVENT: count_evt = run_en && hit_edge;
            MODE_TIMER: count_evt = run_en && psc_tick;
            MODE_PULSE: count_evt = run_en && psc_tick && active_lvl;
            default:    count_evt = 1'b0;
        endcase
        pw_done = run_en && (mode == MODE_PULSE) && end_edge;
    end

    // Purpose: hold the control byte. A bus write beats the end-of-pulse clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data & ~(8'h01 << CB_RSVD);
        else if (pw_done) ctrl_q[CB_RUN] <= 1'b0;
    end

    // Purpose: hold the reload value written at the data address.
    always_ff @(posedge clk) begin
        if (!rst_n)       preload_q <= '0;
        else if (data_wr) preload_q <= wr_data;
    end

    // Purpose: return the live count or the control byte.
    always_comb rd_data = addr ? ctrl_q : cnt_q;

    evt_timer_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_in(ext_in),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    evt_timer_psc #(.CODE_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl_wr),
        .tick_en (tick_en),
        .code    (ctrl_q[PSC_W-1:0]),
        .psc_tick(psc_tick)
    );

    evt_timer_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (count_evt),
        .reload  (preload_q),
        .flag_clr(ctrl_wr),
        .cnt     (cnt_q),
        .ovf_flag(ovf_flag),
        .pfd_out (pfd_out)
    );
endmodule

// File: rtl/evt_timer_chk.sv
// Checker for evt_timer, attached with bind. It observes the ports and a few
// internal registers and assumes the synchronous active-low reset.
module evt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic [7:0] cnt,
    input logic [7:0] preload,
    input logic [7:0] ctrl,
    input logic       count_evt,
    input logic       pw_done,
    input logic       ovf_flag,
    input logic       pfd_out
);
    // R3
    rsvd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr |-> (rd_data[5] == 1'b0));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_evt && cnt != 8'hFF) |=> (cnt == $past(cnt) + 8'd1));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[4] |=> $stable(cnt));

    // R7
    off_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7:6] == 2'b00) |=> $stable(cnt));

    // R8
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_evt && cnt == 8'hFF) |=> (cnt == $past(preload) && ovf_flag && pfd_out != $past(pfd_out)));

    // R9
    pfd_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_out != $past(pfd_out)) |-> ($past(count_evt) && $past(cnt) == 8'hFF));

    // R10
    pulse_end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_done && !(wr_en && addr)) |=> !ctrl[4]);
endmodule

bind evt_timer evt_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .cnt      (cnt_q),
    .preload  (preload_q),
    .ctrl     (ctrl_q),
    .count_evt(count_evt),
    .pw_done  (pw_done),
    .ovf_flag (ovf_flag),
    .pfd_out  (pfd_out)
);

// File: tb/tb_evt_timer.sv
// Directed bench for evt_timer: one task per scenario, each checking its own results.
module tb_evt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick_en = 1'b0;
    logic       ext_in = 1'b0;
    logic       ovf_flag, pfd_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_en(tick_en), .ext_in(ext_in),
        .ovf_flag(ovf_flag), .pfd_out(pfd_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; ext_in = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_ext(input logic v);
        @(negedge clk);
        ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        bus_rd(1'b0, d); check("R1 count", d, 0);
        bus_rd(1'b1, d); check("R1 control", d, 0);
        check("R1 flag", ovf_flag, 0);
        check("R1 pfd", pfd_out, 0);
    endtask

    task automatic t_prescale();
        logic [7:0] d;
        do_reset();
        bus_wr(1'b1, 8'h92);            // timer, run, divide by 8
        ticks(24);
        bus_rd(1'b0, d); check("R4 div8", d, 3);
        bus_wr(1'b1, 8'h97);            // divide by 256
        ticks(512);
        bus_rd(1'b0, d); check("R4 div256", d, 5);
        bus_wr(1'b1, 8'h90);            // divide by 2
        ticks(1);
        bus_wr(1'b1, 8'h90);            // restart the prescaler
        ticks(1);
        bus_rd(1'b0, d); check("R4 restart", d, 5);
    endtask

    task automatic t_event();
        logic [7:0] d;
        do_reset();
        bus_wr(1'b1, 8'h50);            // event, rising edges
        for (int i = 0; i < 3; i++) begin
            set_ext(1'b1); set_ext(1'b0);
        end
        bus_rd(1'b0, d); check("R5 rising", d, 3);
        bus_wr(1'b1, 8'h58);            // falling edges
        set_ext(1'b1);
        bus_rd(1'b0, d); check("R5 rise ignored", d, 3);
        set_ext(1'b0);
        bus_rd(1'b0, d); check("R5 falling", d, 4);
        bus_wr(1'b1, 8'h48);            // run off
        set_ext(1'b1); set_ext(1'b0);
        bus_rd(1'b0, d); check("R6 halted", d, 4);
        bus_wr(1'b1, 8'h10);            // mode 00, run on
        ticks(8);
        set_ext(1'b1); set_ext(1'b0);
        bus_rd(1'b0, d); check("R7 off mode", d, 4);
        bus_wr(1'b1, 8'hFF);
        bus_rd(1'b1, d); check("R3 control read", d, 8'hDF);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        do_reset();
        bus_wr(1'b0, 8'hFC);
        bus_rd(1'b0, d); check("R2 preload only", d, 0);
        bus_wr(1'b1, 8'h90);
        ticks(510);
        bus_rd(1'b0, d); check("R2 live count", d, 8'hFF);
        check("R8 no flag yet", ovf_flag, 0);
        ticks(2);
        bus_rd(1'b0, d); check("R8 reload", d, 8'hFC);
        check("R8 flag", ovf_flag, 1);
        check("R8 pfd", pfd_out, 1);
        ticks(6);
        bus_rd(1'b0, d); check("R9 count", d, 8'hFF);
        check("R9 pfd held", pfd_out, 1);
        ticks(2);
        check("R9 pfd toggled", pfd_out, 0);
        check("R11 flag sticky", ovf_flag, 1);
        bus_wr(1'b1, 8'h10);
        check("R11 flag cleared", ovf_flag, 0);
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        do_reset();
        bus_wr(1'b1, 8'hD0);            // pulse width, high active, divide by 2
        ticks(6);                       // input low: no counting
        set_ext(1'b1);
        ticks(10);
        set_ext(1'b0);
        bus_rd(1'b0, d); check("R10 width", d, 5);
        bus_rd(1'b1, d); check("R10 run cleared", d, 8'hC0);
        set_ext(1'b1);
        ticks(4);
        set_ext(1'b0);
        bus_rd(1'b0, d); check("R10 held", d, 5);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_event();
        t_overflow();
        t_pulse();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule